// File: doc/BRIEF.md
# Dual-Style Parallel Host Bus Slave

This block lets an external microcontroller read and write an 8-bit register file inside the chip over a parallel bus. One instance serves two board wirings. In the shared-line wiring, the host first places the register address on the data lines and marks it with an address strobe. In the split wiring, the host presents the address on its own bus, and the data lines carry only data. A mode pin selects the wiring, and the block takes its value once, right after reset.

All host controls are active low except the address strobe. They are asynchronous to the core clock, so each one passes through a chain of `SYNC_STAGES` flip-flops before the block acts on it. The host must hold address and data on the bus while the matching strobe is low, and for `SYNC_STAGES + 2` core clocks after it. A write takes effect as a single-cycle write pulse toward the register file once the write strobe has gone back high. A read issues a single-cycle read pulse once the read strobe has gone low. The block then captures the returned byte and presents it on the data lines until the strobe rises. The data lines and the ready line are given as a value plus an output enable, and the pad ring turns these into three-state pins. Ready is driven low while the core reports a memory transfer in progress, and is released otherwise.

Top module: `host_bus_port`

## Requirements
- R1: While `host_cs_n` is high (deselected), the address strobe, write strobe and read strobe have no effect: no write pulse, no read pulse, no address change and `host_dq_oe_o` stays 0.
- R2: With `mode_sep_i` = 0 taken at reset (shared lines), the register address is loaded from `host_dq_i` on every cycle in which the synchronized address strobe is high and the chip is selected.
- R3: With `mode_sep_i` = 1 taken at reset (split buses), the register address is loaded from `host_addr_i` on every selected cycle with neither strobe low. The address strobe and `host_dq_i` never change the address.
- R4: `mode_sep_i` is captured on the first clock after reset release. Later changes of the pin do not change the addressing style until the next reset.
- R5: Write data is taken from `host_dq_i` on each selected cycle with the synchronized write strobe low. One cycle after the synchronized strobe rises, `rf_we_o` pulses high for exactly one cycle, with `rf_addr_o` = latched address and `rf_wdata_o` = the last captured byte.
- R6: One cycle after the synchronized read strobe falls (while selected), `rf_re_o` pulses for one cycle. On the next cycle `host_dq_oe_o` rises and `host_dq_o` carries `rf_rdata_i` as it was during the pulse. That value stays unchanged until the synchronized strobe rises or chip select goes high, and then `host_dq_oe_o` drops to 0.
- R7: During reset `host_dq_oe_o`, `host_rdy_oe_o`, `rf_we_o` and `rf_re_o` are 0, so the data lines are inputs and ready is high impedance.
- R8: `host_rdy_oe_o` equals `xfer_busy_i` delayed by one clock, and `host_rdy_n_o` is 0 whenever `host_rdy_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sep_i | input | 1 | Addressing style: 0 shared lines, 1 split buses (taken after reset) |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ale | input | 1 | Host address strobe, active high |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_addr_i | input | AW | Dedicated address bus (split style) |
| host_dq_i | input | DW | Data lines, input side |
| host_dq_o | output | DW | Data lines, output side |
| host_dq_oe_o | output | 1 | Drive enable for the data lines |
| host_rdy_n_o | output | 1 | Ready level, low while a transfer is pending |
| host_rdy_oe_o | output | 1 | Drive enable for ready; 0 means high impedance |
| rf_addr_o | output | AW | Register file address |
| rf_wdata_o | output | DW | Register file write data |
| rf_we_o | output | 1 | Register file write pulse |
| rf_re_o | output | 1 | Register file read pulse |
| rf_rdata_i | input | DW | Register file read data, combinational from `rf_addr_o` |
| xfer_busy_i | input | 1 | Internal register-to-memory transfer in progress |

## Verification
The bench builds the block with `SYNC_STAGES` = 3 rather than the default 2. A reference model that assumes the wrong strobe latency therefore drifts by a cycle and shows up at once. `AW` and `DW` stay at 8, so the bench register file covers the full 256-entry address space. Addresses such as 0x80 reach the top address bit in both styles.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    // Host controls after polarity correction: every field is active high.
    typedef struct packed {
        logic sel;
        logic wr;
        logic rd;
        logic ale;
    } hbus_strobe_t;

    localparam hbus_strobe_t STROBE_IDLE = '0;

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync
    import hbus_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  hbus_strobe_t raw_i,
    output hbus_strobe_t sync_o
);

    typedef struct packed {
        hbus_strobe_t [STAGES-1:0] chain;
    } sync_state_t;

    sync_state_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];

endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch
    import hbus_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sep_i,
    input  hbus_strobe_t  strb_i,
    input  logic [AW-1:0] dq_addr_i,
    input  logic [AW-1:0] bus_addr_i,
    output logic [AW-1:0] addr_o,
    output logic          sep_o,
    output logic          ready_o
);

    typedef struct packed {
        logic          init;
        logic          sep;
        logic [AW-1:0] addr;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Addressing style is frozen after the first post-reset clock.
        if (!st_q.init) begin
            st_d.init = 1'b1;
            st_d.sep  = mode_sep_i;
        end
        if (st_q.sep) begin
            if (strb_i.sel && !strb_i.wr && !strb_i.rd) begin
                st_d.addr = bus_addr_i;
            end
        end else begin
            if (strb_i.sel && strb_i.ale) begin
                st_d.addr = dq_addr_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o  = st_q.addr;
    assign sep_o   = st_q.sep;
    assign ready_o = st_q.init;

endmodule

// File: rtl/hbus_rw_ctrl.sv
module hbus_rw_ctrl
    import hbus_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  hbus_strobe_t  strb_i,
    input  logic [DW-1:0] dq_i,
    input  logic [DW-1:0] rdata_i,
    output logic          we_o,
    output logic          re_o,
    output logic [DW-1:0] wdata_o,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o
);

    typedef struct packed {
        logic          w_arm;
        logic          r_arm;
        logic          we;
        logic          re;
        logic          oe;
        logic [DW-1:0] wdata;
        logic [DW-1:0] hold;
    } rw_state_t;

    rw_state_t st_d, st_q;
    logic      wr_low;
    logic      rd_low;

    always_comb begin
        wr_low = strb_i.sel & strb_i.wr;
        rd_low = strb_i.sel & strb_i.rd;
        st_d   = st_q;

        // Write side: sample while low, commit once the strobe is released.
        st_d.w_arm = wr_low;
        st_d.we    = st_q.w_arm & ~wr_low;
        if (wr_low) begin
            st_d.wdata = dq_i;
        end

        // Read side: request on the falling edge, capture one cycle later.
        st_d.r_arm = rd_low;
        st_d.re    = rd_low & ~st_q.r_arm;
        if (st_q.re) begin
            st_d.hold = rdata_i;
        end
        st_d.oe = st_q.re | (st_q.oe & rd_low);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign we_o    = st_q.we;
    assign re_o    = st_q.re;
    assign wdata_o = st_q.wdata;
    assign dq_o    = st_q.hold;
    assign dq_oe_o = st_q.oe;

endmodule

// File: rtl/hbus_ready.sv
module hbus_ready (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_i,
    output logic rdy_n_o,
    output logic rdy_oe_o
);

    typedef struct packed {
        logic drive;
    } rdy_state_t;

    rdy_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.drive = busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_oe_o = st_q.drive;
    assign rdy_n_o  = ~st_q.drive;

endmodule

// File: rtl/host_bus_port.sv
module host_bus_port
    import hbus_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sep_i,
    input  logic          host_cs_n,
    input  logic          host_ale,
    input  logic          host_wr_n,
    input  logic          host_rd_n,
    input  logic [AW-1:0] host_addr_i,
    input  logic [DW-1:0] host_dq_i,
    output logic [DW-1:0] host_dq_o,
    output logic          host_dq_oe_o,
    output logic          host_rdy_n_o,
    output logic          host_rdy_oe_o,
    output logic [AW-1:0] rf_addr_o,
    output logic [DW-1:0] rf_wdata_o,
    output logic          rf_we_o,
    output logic          rf_re_o,
    input  logic [DW-1:0] rf_rdata_i,
    input  logic          xfer_busy_i
);

    localparam int SHARED_AW = (AW < DW) ? AW : DW;

    hbus_strobe_t  strb_raw;
    hbus_strobe_t  strb_sync;
    logic [AW-1:0] dq_addr;
    logic          mode_sep_w;
    logic          mode_ready_w;

    always_comb begin
        strb_raw     = STROBE_IDLE;
        strb_raw.sel = ~host_cs_n;
        strb_raw.wr  = ~host_wr_n;
        strb_raw.rd  = ~host_rd_n;
        strb_raw.ale = host_ale;
        dq_addr      = '0;
        dq_addr[SHARED_AW-1:0] = host_dq_i[SHARED_AW-1:0];
    end

    hbus_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (strb_raw),
        .sync_o (strb_sync)
    );

    hbus_addr_latch #(
        .AW (AW)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sep_i (mode_sep_i),
        .strb_i     (strb_sync),
        .dq_addr_i  (dq_addr),
        .bus_addr_i (host_addr_i),
        .addr_o     (rf_addr_o),
        .sep_o      (mode_sep_w),
        .ready_o    (mode_ready_w)
    );

    hbus_rw_ctrl #(
        .DW (DW)
    ) u_rw (
        .clk     (clk),
        .rst_n   (rst_n),
        .strb_i  (strb_sync),
        .dq_i    (host_dq_i),
        .rdata_i (rf_rdata_i),
        .we_o    (rf_we_o),
        .re_o    (rf_re_o),
        .wdata_o (rf_wdata_o),
        .dq_o    (host_dq_o),
        .dq_oe_o (host_dq_oe_o)
    );

    hbus_ready u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .busy_i   (xfer_busy_i),
        .rdy_n_o  (host_rdy_n_o),
        .rdy_oe_o (host_rdy_oe_o)
    );

endmodule

// File: rtl/host_bus_port_checker.sv
module host_bus_port_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          xfer_busy_i,
    input logic          dq_oe,
    input logic [DW-1:0] dq_out,
    input logic          we,
    input logic          re,
    input logic          rdy_oe,
    input logic          rdy_n,
    input logic          mode_sep,
    input logic          mode_ready
);

    assert_reset_quiet_R7: assert property (@(posedge clk)
        !rst_n |=> (!dq_oe && !we && !re));

    assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> !we);

    assert_re_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> !re);

    assert_oe_after_re_R6: assert property (@(posedge clk) disable iff (!rst_n)
        re |=> dq_oe);

    assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

    assert_rdy_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_busy_i |=> rdy_oe);

    assert_rdy_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_busy_i |=> !rdy_oe);

    assert_rdy_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_oe |-> !rdy_n);

    assert_mode_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_ready && $past(mode_ready)) |-> $stable(mode_sep));

endmodule

bind host_bus_port host_bus_port_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .xfer_busy_i (xfer_busy_i),
    .dq_oe       (host_dq_oe_o),
    .dq_out      (host_dq_o),
    .we          (rf_we_o),
    .re          (rf_re_o),
    .rdy_oe      (host_rdy_oe_o),
    .rdy_n       (host_rdy_n_o),
    .mode_sep    (mode_sep_w),
    .mode_ready  (mode_ready_w)
);

// File: tb/host_bus_port_test.sv
module host_bus_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sep = 1'b0;
    logic       cs_n = 1'b1;
    logic       ale = 1'b0;
    logic       wr_n = 1'b1;
    logic       rd_n = 1'b1;
    logic [7:0] addr_in = '0;
    logic [7:0] dq_in = '0;
    logic       busy = 1'b0;
    logic [7:0] dq_out;
    logic       dq_oe;
    logic       rdy_n;
    logic       rdy_oe;
    logic [7:0] rf_addr;
    logic [7:0] rf_wdata;
    logic       rf_we;
    logic       rf_re;
    logic [7:0] rf_rdata;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic [7:0] env_mem [256];
    logic [7:0] ref_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    host_bus_port #(.AW(8), .DW(8), .SYNC_STAGES(SYNC)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_sep_i    (mode_sep),
        .host_cs_n     (cs_n),
        .host_ale      (ale),
        .host_wr_n     (wr_n),
        .host_rd_n     (rd_n),
        .host_addr_i   (addr_in),
        .host_dq_i     (dq_in),
        .host_dq_o     (dq_out),
        .host_dq_oe_o  (dq_oe),
        .host_rdy_n_o  (rdy_n),
        .host_rdy_oe_o (rdy_oe),
        .rf_addr_o     (rf_addr),
        .rf_wdata_o    (rf_wdata),
        .rf_we_o       (rf_we),
        .rf_re_o       (rf_re),
        .rf_rdata_i    (rf_rdata),
        .xfer_busy_i   (busy)
    );

    // Register file environment seen by the design.
    initial begin
        for (int i = 0; i < 256; i++) begin
            env_mem[i] = 8'(i) ^ 8'h5A;
            ref_mem[i] = 8'(i) ^ 8'h5A;
        end
    end
    assign rf_rdata = env_mem[rf_addr];
    always @(posedge clk) if (rf_we) env_mem[rf_addr] <= rf_wdata;

    // Behavioural cycle model of the port.
    logic [3:0] hist [$];
    logic [7:0] m_addr, m_wdata, m_hold;
    logic       m_init, m_sep, m_armed, m_we, m_rarm, m_re, m_oe, m_rdy;

    always @(posedge clk or negedge rst_n) begin
        logic [3:0] s;
        logic       wl, rl, n_we, n_re, n_oe;
        logic [7:0] n_addr, n_hold;
        if (!rst_n) begin
            hist.delete();
            m_addr = 0; m_wdata = 0; m_hold = 0; m_init = 0; m_sep = 0;
            m_armed = 0; m_we = 0; m_rarm = 0; m_re = 0; m_oe = 0; m_rdy = 0;
        end else begin
            s = (hist.size() >= SYNC) ? hist[hist.size()-SYNC] : 4'b0;
            hist.push_back({~cs_n, ~wr_n, ~rd_n, ale});
            if (hist.size() > SYNC) void'(hist.pop_front());
            wl = s[3] & s[2];
            rl = s[3] & s[1];
            n_addr = m_addr;
            if (!m_sep && s[3] && s[0]) n_addr = dq_in;
            if (m_sep && s[3] && !s[2] && !s[1]) n_addr = addr_in;
            n_hold = m_re ? ref_mem[m_addr] : m_hold;
            if (m_we) ref_mem[m_addr] = m_wdata;
            n_we = m_armed & ~wl;
            n_re = rl & ~m_rarm;
            n_oe = m_re | (m_oe & rl);
            if (wl) m_wdata = dq_in;
            if (!m_init) begin m_init = 1; m_sep = mode_sep; end
            m_armed = wl; m_rarm = rl;
            m_we = n_we; m_re = n_re; m_oe = n_oe; m_hold = n_hold;
            m_addr = n_addr; m_rdy = busy;
        end
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R6 dq_oe", dq_oe, m_oe);
            if (m_oe) check("R6 dq_out", dq_out, m_hold);
            check("R5 we", rf_we, m_we);
            if (m_we) begin
                check("R5 we addr (R2/R3)", rf_addr, m_addr);
                check("R5 wdata", rf_wdata, m_wdata);
            end
            check("R6 re", rf_re, m_re);
            if (m_re) check("R6 re addr (R2/R3)", rf_addr, m_addr);
            check("R8 rdy_oe", rdy_oe, m_rdy);
            if (m_rdy) check("R8 rdy_n", rdy_n, 1'b0);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(logic sep);
        rst_n = 1'b0; mode_sep = sep; cs_n = 1'b1; ale = 1'b0;
        wr_n = 1'b1; rd_n = 1'b1; busy = 1'b0;
        tick(4);
        check("R7 dq_oe in reset", dq_oe, 1'b0);
        check("R7 rdy_oe in reset", rdy_oe, 1'b0);
        check("R7 pulses in reset", {rf_we, rf_re}, 2'b00);
        rst_n = 1'b1;
        tick(3);
    endtask

    task automatic bus_write(bit shared, logic [7:0] a, logic [7:0] d, logic [7:0] junk);
        cs_n = 1'b0;
        if (shared) begin
            dq_in = a; ale = 1'b1; tick(4); ale = 1'b0; tick(SYNC + 2);
        end else begin
            addr_in = a; dq_in = junk; ale = 1'b1; tick(SYNC + 2); ale = 1'b0;
        end
        dq_in = d; wr_n = 1'b0; tick(4); wr_n = 1'b1;
        tick(SYNC + 3); cs_n = 1'b1; tick(SYNC + 2);
    endtask

    task automatic bus_read(bit shared, logic [7:0] a, logic [7:0] exp, string tag);
        cs_n = 1'b0;
        if (shared) begin
            dq_in = a; ale = 1'b1; tick(4); ale = 1'b0; tick(SYNC + 2);
        end else begin
            addr_in = a; tick(SYNC + 2);
        end
        dq_in = 8'h00; rd_n = 1'b0; tick(SYNC + 4);
        check({tag, " R6 oe while reading"}, dq_oe, 1'b1);
        check({tag, " read data"}, dq_out, exp);
        tick(2);
        check({tag, " R6 data held"}, dq_out, exp);
        rd_n = 1'b1; tick(SYNC + 3);
        check({tag, " R6 oe released"}, dq_oe, 1'b0);
        cs_n = 1'b1; tick(SYNC + 2);
    endtask

    initial begin
        // Shared address/data lines.
        do_reset(1'b0);
        bus_write(1'b1, 8'h21, 8'hA5, 8'h00);
        bus_read(1'b1, 8'h21, 8'hA5, "R2 R5");
        bus_write(1'b1, 8'h80, 8'h3C, 8'h00);
        bus_read(1'b1, 8'h80, 8'h3C, "R2 top bit");
        bus_read(1'b1, 8'h21, 8'hA5, "R2 other entry kept");
        bus_read(1'b1, 8'h07, 8'h07 ^ 8'h5A, "R6 untouched entry");

        // Strobes while deselected.
        cs_n = 1'b1; dq_in = 8'h21; ale = 1'b1; tick(4); ale = 1'b0;
        dq_in = 8'hFF; wr_n = 1'b0; tick(4); wr_n = 1'b1;
        rd_n = 1'b0; tick(SYNC + 4);
        check("R1 no drive when deselected", dq_oe, 1'b0);
        rd_n = 1'b1; tick(SYNC + 3);
        bus_read(1'b1, 8'h21, 8'hA5, "R1 write ignored");

        // Ready follows the internal transfer flag.
        busy = 1'b1; tick(1);
        check("R8 ready driven", rdy_oe, 1'b1);
        check("R8 ready low", rdy_n, 1'b0);
        tick(3); busy = 1'b0; tick(1);
        check("R8 ready released", rdy_oe, 1'b0);

        // Split buses; mode pin flips after reset and must be ignored.
        do_reset(1'b1);
        mode_sep = 1'b0;
        bus_write(1'b0, 8'h10, 8'h77, 8'h21);
        bus_read(1'b0, 8'h10, 8'h77, "R3 R4 split write");
        bus_read(1'b0, 8'h21, 8'hA5, "R3 strobe on shared lines ignored");
        bus_write(1'b0, 8'hFF, 8'hC3, 8'h10);
        bus_read(1'b0, 8'hFF, 8'hC3, "R3 last entry");
        bus_read(1'b0, 8'h10, 8'h77, "R4 style kept");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired before the sequence ended");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule